// File: doc/BRIEF.md
# Key-Started Independent Watchdog Timer

This block is a watchdog that counts in its own low-speed clock domain. Its clock is separate from the bus clock, so it keeps counting and can still fire if the bus clock stops. Software controls it only through 16-bit key writes and two configuration registers on a simple write port in the bus clock domain.

A start key launches a free-running 12-bit downcounter, and nothing but expiry stops it again. Software has to feed the watchdog with a refresh key before the counter runs out. If the count reaches zero, the block emits a one-cycle reset pulse in the watchdog domain and falls back to its stopped state.

A separate unlock key opens the prescaler and reload registers for writing. Configuration changes cross into the watchdog domain through a toggle handshake, and a busy flag shows while a change is in transit.

Top module: `key_watchdog`

## Requirements
- R1: Writes to address 0 are key writes. Key 0xCCCC starts the counter. While stopped, `count_o` holds 0xFFF, and counting begins from 0xFFF.
- R2: Once running, the counter steps down by one every N watchdog-clock cycles, where N is the prescaler ratio (4 after reset).
- R3: Address 1, bits [2:0], holds a prescaler code c. The ratio is 4·2^c for c = 0..6, and code 7 also gives 256.
- R4: Key 0xAAAA loads the counter from the reload register (address 2, bits [11:0], reset value 0xFFF) and restarts the prescaler phase. From the first cycle the reloaded value R shows on `count_o`, the reset pulse follows R·N+1 watchdog cycles later.
- R5: Key 0x5555 unlocks the prescaler and reload registers. Any other key value locks them again, and writes to them while locked have no effect.
- R6: No reset pulse is produced unless the watchdog was started.
- R7: A running counter that reaches 0x000 produces a reset pulse exactly one watchdog cycle wide. In that same cycle the block returns to the stopped state with the count at 0xFFF.
- R8: A start key written while running acts as a reload. No key write can stop a running watchdog.
- R9: `busy_o` rises the bus cycle after an accepted prescaler or reload write and falls once the watchdog domain acknowledges it. Configuration writes made while busy are ignored.
- R10: Counting and expiry continue while the bus clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| wdclk_i | input | 1 | Dedicated low-speed watchdog clock |
| wr_en_i | input | 1 | Register write strobe (bus domain) |
| wr_addr_i | input | 2 | Register select: 0 key, 1 prescaler, 2 reload |
| wr_data_i | input | 16 | Write data |
| busy_o | output | 1 | Configuration update in transit (bus domain) |
| wd_reset_o | output | 1 | Watchdog reset pulse (watchdog domain) |
| count_o | output | 12 | Current counter value (watchdog domain) |

## Verification
The hardest states to reach from the ports are a second configuration write that lands while the first is still crossing domains, and expiry with the bus clock halted. The bench issues two reload writes on back-to-back bus cycles. The value that later loads must be the first one. For the clock case, the bench gates its own bus clock after a refresh and watches the count fall and the pulse fire with no bus edges at all. Expiry timing is pinned exactly: the bench counts watchdog cycles from the first sample of a freshly loaded small reload value.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_FEED   = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;

  typedef enum logic [1:0] {
    REG_KEY = 2'd0,
    REG_PRE = 2'd1,
    REG_RLD = 2'd2
  } reg_sel_e;

  // cross-domain event slots
  localparam int EV_START = 0;
  localparam int EV_FEED  = 1;
  localparam int EV_CFG   = 2;
  localparam int EV_N     = 3;
endpackage

// File: rtl/wdg_toggle_sync.sv
module wdg_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], tgl_i};
  end

  assign pulse_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/wdg_bus_if.sv
module wdg_bus_if
  import wdg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PR_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [KEY_W-1:0] wr_data_i,
  input  logic             ack_pulse_i,
  output logic [PR_W-1:0]  pre_o,
  output logic [CNT_W-1:0] rld_o,
  output logic [EV_N-1:0]  ev_tgl_o,
  output logic             busy_o
);
  logic             unlock_q, busy_q;
  logic [PR_W-1:0]  pre_q;
  logic [CNT_W-1:0] rld_q;
  logic [EV_N-1:0]  tgl_q;
  logic             cfg_ok;

  assign cfg_ok = wr_en_i && unlock_q && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      busy_q   <= 1'b0;
      pre_q    <= '0;
      rld_q    <= '1;
      tgl_q    <= '0;
    end else begin
      if (ack_pulse_i) busy_q <= 1'b0;
      if (wr_en_i) begin
        unique case (reg_sel_e'(wr_addr_i))
          REG_KEY: begin
            unlock_q <= (wr_data_i == KEY_UNLOCK);
            if (wr_data_i == KEY_START) tgl_q[EV_START] <= ~tgl_q[EV_START];
            if (wr_data_i == KEY_FEED)  tgl_q[EV_FEED]  <= ~tgl_q[EV_FEED];
          end
          REG_PRE: if (cfg_ok) begin
            pre_q          <= wr_data_i[PR_W-1:0];
            tgl_q[EV_CFG]  <= ~tgl_q[EV_CFG];
            busy_q         <= 1'b1;
          end
          REG_RLD: if (cfg_ok) begin
            rld_q          <= wr_data_i[CNT_W-1:0];
            tgl_q[EV_CFG]  <= ~tgl_q[EV_CFG];
            busy_q         <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign pre_o    = pre_q;
  assign rld_o    = rld_q;
  assign ev_tgl_o = tgl_q;
  assign busy_o   = busy_q;
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PR_W    = 3,
  parameter int BASE_SH = 2,
  parameter int MAX_SH  = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic [PR_W-1:0] code_i,
  output logic            tick_o
);
  localparam int DIV_W = MAX_SH;

  logic [DIV_W-1:0] cnt_q, lim;

  always_comb begin
    int unsigned sh;
    sh = BASE_SH + int'(code_i);
    if (sh > MAX_SH) sh = MAX_SH;
    lim = DIV_W'((32'd1 << sh) - 32'd1);
  end

  // >= keeps a shortened ratio from overrunning mid-phase
  assign tick_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || clr_i)  cnt_q <= '0;
    else if (tick_o)           cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             feed_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] rld_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             load_o,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, pulse_q, expire;

  assign expire = run_q && (cnt_q == '0);
  // expiry outranks a refresh arriving in the same cycle
  assign load_o = run_q && !expire && (feed_i || start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '1;
      run_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (expire) begin
        pulse_q <= 1'b1;
        run_q   <= 1'b0;
        cnt_q   <= '1;
      end else if (load_o) begin
        cnt_q <= rld_i;
      end else if (!run_q && start_i) begin
        run_q <= 1'b1;
      end else if (run_q && tick_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign count_o = cnt_q;
  assign run_o   = run_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import wdg_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int PR_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wdclk_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [KEY_W-1:0] wr_data_i,
  output logic             busy_o,
  output logic             wd_reset_o,
  output logic [CNT_W-1:0] count_o
);
  logic [PR_W-1:0]  pre_bus, pre_wd;
  logic [CNT_W-1:0] rld_bus, rld_wd;
  logic [EV_N-1:0]  ev_tgl, ev_pulse;
  logic             ack_q, ack_pulse;
  logic             run_w, load_w, tick_w;

  wdg_bus_if #(.CNT_W(CNT_W), .PR_W(PR_W)) u_bus (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ack_pulse_i(ack_pulse),
    .pre_o(pre_bus), .rld_o(rld_bus),
    .ev_tgl_o(ev_tgl), .busy_o
  );

  for (genvar g = 0; g < EV_N; g++) begin : g_ev
    wdg_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(wdclk_i), .rst_ni, .tgl_i(ev_tgl[g]), .pulse_o(ev_pulse[g])
    );
  end

  // bus shadows are frozen while busy, so sampling here is safe
  always_ff @(posedge wdclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_wd <= '0;
      rld_wd <= '1;
      ack_q  <= 1'b0;
    end else if (ev_pulse[EV_CFG]) begin
      pre_wd <= pre_bus;
      rld_wd <= rld_bus;
      ack_q  <= ~ack_q;
    end
  end

  wdg_toggle_sync #(.STAGES(SYNC_STAGES)) u_ack (
    .clk_i, .rst_ni, .tgl_i(ack_q), .pulse_o(ack_pulse)
  );

  wdg_prescaler #(.PR_W(PR_W)) u_pre (
    .clk_i(wdclk_i), .rst_ni, .run_i(run_w), .clr_i(load_w),
    .code_i(pre_wd), .tick_o(tick_w)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i(wdclk_i), .rst_ni,
    .start_i(ev_pulse[EV_START]), .feed_i(ev_pulse[EV_FEED]),
    .tick_i(tick_w), .rld_i(rld_wd),
    .count_o, .run_o(run_w), .load_o(load_w), .pulse_o(wd_reset_o)
  );
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             wdclk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             busy_o,
  input logic             wd_reset_o,
  input logic [CNT_W-1:0] count_o,
  input logic             run_i
);
  AST_PULSE_SINGLE: assert property (@(posedge wdclk_i) disable iff (!rst_ni)
    wd_reset_o |=> !wd_reset_o); // R7
  AST_PULSE_AT_ZERO: assert property (@(posedge wdclk_i) disable iff (!rst_ni)
    $rose(wd_reset_o) |-> ($past(count_o) == '0) && (count_o == '1)); // R7
  AST_NO_PULSE_IDLE: assert property (@(posedge wdclk_i) disable iff (!rst_ni)
    wd_reset_o |-> $past(run_i)); // R6
  AST_IDLE_FULL: assert property (@(posedge wdclk_i) disable iff (!rst_ni)
    !run_i |-> (count_o == '1)); // R1
  AST_NO_STOP: assert property (@(posedge wdclk_i) disable iff (!rst_ni)
    $fell(run_i) |-> wd_reset_o); // R8
  AST_BUSY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en_i)); // R9
endmodule

bind key_watchdog wdg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .wdclk_i, .rst_ni, .wr_en_i, .busy_o, .wd_reset_o, .count_o,
  .run_i(run_w)
);

// File: tb/tb_key_watchdog.sv
module tb_key_watchdog;
  logic        clk = 1'b0, wdclk = 1'b0, clk_run = 1'b1;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy, wdr;
  logic [11:0] count;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = clk_run ? ~clk : clk;  // 50 MHz, gateable
  always #15 wdclk = ~wdclk;

  key_watchdog dut (
    .clk_i(clk), .rst_ni(rst_n), .wdclk_i(wdclk), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .busy_o(busy),
    .wd_reset_o(wdr), .count_o(count)
  );

  // prescaler code = index, expected ratio = value
  localparam int unsigned VEC_DIV [8] = '{4, 8, 16, 32, 64, 128, 256, 256};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_wd(input int n);
    for (int i = 0; i < n; i++) @(negedge wdclk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
  endtask

  task automatic measure_div(output int n);
    logic [11:0] prev;
    prev = count;
    for (int g = 0; g < 2000 && count == prev; g++) @(negedge wdclk);
    prev = count; n = 0;
    while (count == prev && n < 2000) begin @(negedge wdclk); n++; end
  endtask

  task automatic wait_pulse(input int lim, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < lim && !seen; i++) begin
      @(negedge wdclk);
      seen = wdr;
    end
  endtask

  initial begin
    #3_500_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int  n;
    bit  seen, any;
    logic [11:0] prev;

    repeat (3) @(negedge clk);
    chk(count == 12'hFFF, "R1", "reset count", count, 12'hFFF);
    chk(!wdr && !busy, "R1", "reset outputs", {wdr, busy}, 0);
    rst_n = 1'b1;

    // R6: idle, never started
    any = 1'b0;
    for (int i = 0; i < 200; i++) begin @(negedge wdclk); any |= wdr; end
    chk(!any, "R6", "pulse while idle", any, 0);
    chk(count == 12'hFFF, "R1", "idle count", count, 12'hFFF);

    // R1/R2: start and default ratio
    wr(2'd0, 16'hCCCC);
    wait_wd(20);
    chk(count < 12'hFFF && count > 12'hFF0, "R1", "counting after start", count, 12'hFFD);
    measure_div(n);
    chk(n == 4, "R2", "default ratio", n, 4);

    // R3: table walk over prescaler codes
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, 16'h5555);
      wr(2'd1, 16'(c));
      chk(busy, "R9", "busy after cfg write", busy, 1);
      wait_idle();
      wr(2'd0, 16'hAAAA);
      wait_wd(10);
      measure_div(n);
      chk(n == int'(VEC_DIV[c]), "R3", $sformatf("ratio code %0d", c), n, VEC_DIV[c]);
    end
    chk(!busy, "R9", "busy cleared", busy, 0);

    // R5: locked writes ignored
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'h0000);
    wait_idle();
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0020);
    wr(2'd0, 16'hAAAA);
    wait_wd(12);
    chk(count > 12'h100, "R5", "reload after locked write", count, 12'hFFF);

    // R4/R7: exact expiry timing with reload 0x20, ratio 4
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'h0020);
    wait_idle();
    wr(2'd0, 16'hAAAA);
    for (int g = 0; g < 200 && count != 12'h020; g++) @(negedge wdclk);
    n = 0; seen = 1'b0;
    while (!seen && n < 400) begin @(negedge wdclk); n++; seen = wdr; end
    chk(n == 129, "R4", "cycles from reload to pulse", n, 129);
    chk(count == 12'hFFF, "R7", "count during pulse", count, 12'hFFF);
    @(negedge wdclk);
    chk(!wdr, "R7", "pulse width", wdr, 0);
    any = 1'b0;
    for (int i = 0; i < 300; i++) begin @(negedge wdclk); any |= wdr; end
    chk(!any && count == 12'hFFF, "R7", "stopped after pulse", count, 12'hFFF);

    // R8: restart key acts as reload, other keys cannot stop
    wr(2'd0, 16'hCCCC);
    wait_wd(20);
    wr(2'd0, 16'hCCCC);
    wait_wd(10);
    chk(count <= 12'h020 && count >= 12'h01C, "R8", "start key reloads", count, 12'h020);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h1234);
    wait_pulse(400, seen);
    chk(seen, "R8", "still expires after other keys", seen, 1);

    // R9: second cfg write while busy is dropped
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'h5555);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0030;
    @(negedge clk);
    wr_data = 16'h0040;
    @(negedge clk);
    wr_en = 1'b0;
    wait_idle();
    wr(2'd0, 16'hAAAA);
    wait_wd(8);
    chk(count <= 12'h030 && count >= 12'h02C, "R9", "write while busy ignored", count, 12'h030);

    // R10: bus clock halted
    wr(2'd0, 16'hAAAA);
    @(negedge clk);
    clk_run = 1'b0;
    wait_wd(8);
    prev = count;
    wait_wd(100);
    chk(count < prev, "R10", "counting without bus clock", count, prev - 1);
    wait_pulse(400, seen);
    chk(seen, "R10", "expiry without bus clock", seen, 1);
    clk_run = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule